// File: doc/BRIEF.md
# Multiplexed Bank Address Demultiplexer

This block joins a processor core with a 16-bit address bus to a memory system that uses 24-bit addresses. During the low phase of the phase-2 clock, the core places the top address byte (the bank) on its 8-bit data bus. The block catches that byte with a flop-based transparent latch and appends it to the low address, which gives a full 24-bit address. When the core runs in emulation mode, it drives no bank byte. In that mode the upper address byte is forced to zero.

Each bus cycle is classified from two valid-address flags, one for data accesses and one for program accesses, together with the read/write line. From that classification the block drives:

- a memory read strobe;
- a memory write strobe;
- a single chip select for a base/mask address window;
- a driver enable for the data buffer that points toward the core.

A low ready input stalls the bus. During a stall the latched bank and the captured transfer direction are frozen, so the strobes and the driver do not change. All logic runs on a fast system clock, and phase 2 is sampled as a level.

Top module: `bad_bank_demux`

## Requirements
- R1: `cyc_type` is {data_valid, prog_valid}. 2'b11 is an opcode fetch, 2'b01 is an operand fetch, 2'b10 is a data access and 2'b00 is an internal cycle.
- R2: When `phi2` is low and ready is high, the bank byte of `addr_full[23:16]` follows `bus_in` combinationally. When `phi2` is high, it shows the `bus_in` value captured at the last clock edge where `phi2` was low. `addr_full[15:0]` always equals `addr_lo`.
- R3: `mem_rd` is high only when all of these hold: armed, `phi2` high, the effective direction is read (`rd_wr_n`=1), and at least one valid flag is high. An internal read cycle never produces `mem_rd`.
- R4: `mem_wr` is high when armed, `phi2` is high and the effective direction is write. This does not depend on the valid flags. `mem_rd` and `mem_wr` are never high together.
- R5: While `rdy` is low, `addr_full[23:16]` holds the captured bank and ignores `bus_in`. The effective direction stays at the `rd_wr_n` value captured at the last clock edge where `rdy` was high, so `mem_rd`, `mem_wr` and `core_drv_en` do not follow `rd_wr_n`.
- R6: `core_drv_en` is high only when armed, `phi2` is high and the effective direction is read.
- R7: When `emul` is high, `addr_full[23:16]` is zero regardless of `bus_in`.
- R8: `periph_cs` is high when `mem_rd` or `mem_wr` is high and ((`addr_full` ^ `win_base`) & `win_mask`) == 0. It is therefore blocked on internal read cycles.
- R9: After reset the captured bank is zero and all strobes are inactive. The block arms at the first clock edge with `phi2` low. A `phi2`-high phase that begins before that edge produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phi2 | input | 1 | Phase-2 level from the core clock |
| rdy | input | 1 | Ready; low stalls the bus |
| emul | input | 1 | Emulation mode, no bank byte on the bus |
| data_valid | input | 1 | Core flag: valid data address |
| prog_valid | input | 1 | Core flag: valid program address |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr_lo | input | 16 | Low address from the core |
| bus_in | input | 8 | Core data bus (carries the bank byte in phase 1) |
| win_base | input | 24 | Chip-select window base |
| win_mask | input | 24 | Chip-select window compare mask |
| addr_full | output | 24 | Formed 24-bit address |
| cyc_type | output | 2 | Cycle classification |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| periph_cs | output | 1 | Window chip select |
| core_drv_en | output | 1 | Enable for the buffer driving toward the core |

## Verification
Full bus cycles are run with every combination of the two valid flags, for both reads and writes. This separates the four cycle types and shows that only internal reads lose their strobes, while writes go through regardless of the flags. Bank bytes that differ between phase 1 and phase 2 show whether the latch holds or stays transparent. Running the same cycle with emulation set shows that the bus byte is discarded. A stall in which the direction and the bus byte are changed in the middle tells a frozen direction apart from a live one. Window tests use addresses that match only in the masked bits, addresses that differ in a masked bit, and a matching address on an internal read.

// File: rtl/bad_pkg.sv
package bad_pkg;
   typedef enum logic [1:0] {
      CYC_INTERNAL = 2'b00,
      CYC_OPERAND  = 2'b01,
      CYC_DATA     = 2'b10,
      CYC_OPCODE   = 2'b11
   } cyc_t;
endpackage

// File: rtl/bad_bank_latch.sv
module bad_bank_latch #(
   parameter int BANK_W  = 8,
   parameter bit EMUL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic              rdy,
   input  logic              emul,
   input  logic [BANK_W-1:0] bus_in,
   output logic [BANK_W-1:0] bank_out
);
   logic [BANK_W-1:0] bank_q;
   logic              open_w;
   logic [BANK_W-1:0] bank_raw;

   // latch is open in phase 1, never while stalled
   assign open_w   = rdy && !phi2;
   assign bank_raw = open_w ? bus_in : bank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bank_q <= '0;
      else if (open_w) bank_q <= bus_in;
   end

   generate
      if (EMUL_EN) begin : g_emul
         assign bank_out = emul ? '0 : bank_raw;
         p_emul_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            emul |-> (bank_out == '0))
            else $error("emulation bank not zero");
      end else begin : g_native
         logic unused_emul;
         assign unused_emul = emul;
         assign bank_out = bank_raw;
      end
   endgenerate

   p_bank_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |=> $stable(bank_q))
      else $error("bank moved during stall");
   p_bank_phase2_r2: assert property (@(posedge clk) disable iff (!rst_n)
      phi2 |=> $stable(bank_q))
      else $error("bank moved in phase 2");
endmodule

// File: rtl/bad_cycle_qual.sv
module bad_cycle_qual
   import bad_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic phi2,
   input  logic rdy,
   input  logic data_valid,
   input  logic prog_valid,
   input  logic rd_wr_n,
   output cyc_t cyc_type,
   output logic rd_en,
   output logic wr_en,
   output logic drv_en
);
   logic dir_q;
   logic armed_q;
   logic dir_eff;
   logic addr_ok;
   logic live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= 1'b1;
         armed_q <= 1'b0;
      end else begin
         if (rdy)   dir_q   <= rd_wr_n;
         if (!phi2) armed_q <= 1'b1;
      end
   end

   assign dir_eff  = rdy ? rd_wr_n : dir_q;
   assign cyc_type = cyc_t'({data_valid, prog_valid});
   assign addr_ok  = (cyc_type != CYC_INTERNAL);
   assign live     = armed_q && phi2;
   assign rd_en    = live && dir_eff && addr_ok;
   assign wr_en    = live && !dir_eff;
   assign drv_en   = live && dir_eff;

   p_no_internal_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_valid && !prog_valid) |-> !rd_en)
      else $error("read strobe on internal cycle");
   p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en))
      else $error("read and write together");
   p_drv_phase2_r6: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> (phi2 && !wr_en))
      else $error("driver on outside read phase 2");
   p_dir_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy && phi2 && armed_q) |=> (!rdy && phi2) |-> $stable(drv_en))
      else $error("direction moved during stall");
   p_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> !(rd_en || wr_en || drv_en))
      else $error("strobe before arming");
endmodule

// File: rtl/bad_window.sv
module bad_window #(
   parameter int ADDR_W = 24
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] mask,
   output logic              hit
);
   logic [ADDR_W-1:0] bit_ok;

   generate
      for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
         assign bit_ok[i] = !mask[i] || (addr[i] == base[i]);
      end
   endgenerate

   assign hit = &bit_ok;
endmodule

// File: rtl/bad_bank_demux.sv
module bad_bank_demux
   import bad_pkg::*;
#(
   parameter int LO_W    = 16,
   parameter int BANK_W  = 8,
   parameter bit EMUL_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   phi2,
   input  logic                   rdy,
   input  logic                   emul,
   input  logic                   data_valid,
   input  logic                   prog_valid,
   input  logic                   rd_wr_n,
   input  logic [LO_W-1:0]        addr_lo,
   input  logic [BANK_W-1:0]      bus_in,
   input  logic [LO_W+BANK_W-1:0] win_base,
   input  logic [LO_W+BANK_W-1:0] win_mask,
   output logic [LO_W+BANK_W-1:0] addr_full,
   output logic [1:0]             cyc_type,
   output logic                   mem_rd,
   output logic                   mem_wr,
   output logic                   periph_cs,
   output logic                   core_drv_en
);
   localparam int FULL_W = LO_W + BANK_W;

   generate
      if (LO_W < 1)   begin : g_bad_lo   $error("LO_W must be positive");   end
      if (BANK_W < 1) begin : g_bad_bank $error("BANK_W must be positive"); end
   endgenerate

   logic [BANK_W-1:0] bank_w;
   cyc_t              cyc_w;
   logic              hit_w;

   bad_bank_latch #(.BANK_W(BANK_W), .EMUL_EN(EMUL_EN)) i_latch (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .rdy(rdy), .emul(emul),
      .bus_in(bus_in), .bank_out(bank_w)
   );

   bad_cycle_qual i_qual (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .rdy(rdy),
      .data_valid(data_valid), .prog_valid(prog_valid), .rd_wr_n(rd_wr_n),
      .cyc_type(cyc_w), .rd_en(mem_rd), .wr_en(mem_wr), .drv_en(core_drv_en)
   );

   assign addr_full = {bank_w, addr_lo};
   assign cyc_type  = cyc_w;

   bad_window #(.ADDR_W(FULL_W)) i_win (
      .addr(addr_full), .base(win_base), .mask(win_mask), .hit(hit_w)
   );

   assign periph_cs = hit_w && (mem_rd || mem_wr);

   p_cs_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      periph_cs |-> (mem_rd || mem_wr))
      else $error("chip select without strobe");
   p_cs_internal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 2'b00 && core_drv_en) |-> !periph_cs)
      else $error("chip select on internal read");
endmodule

// File: tb/test_bad_bank_demux.sv
module test_bad_bank_demux;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phi2 = 1'b1, rdy = 1'b1, emul = 1'b0;
   logic        data_valid = 1'b0, prog_valid = 1'b0, rd_wr_n = 1'b1;
   logic [15:0] addr_lo = '0;
   logic [7:0]  bus_in = '0;
   logic [23:0] win_base = 24'h120000, win_mask = 24'hFF0000;
   logic [23:0] addr_full;
   logic [1:0]  cyc_type;
   logic        mem_rd, mem_wr, periph_cs, core_drv_en;
   int          checks = 0, fails = 0;

   always #5 clk = ~clk;

   bad_bank_demux i_bad_bank_demux (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .rdy(rdy), .emul(emul),
      .data_valid(data_valid), .prog_valid(prog_valid), .rd_wr_n(rd_wr_n),
      .addr_lo(addr_lo), .bus_in(bus_in), .win_base(win_base), .win_mask(win_mask),
      .addr_full(addr_full), .cyc_type(cyc_type), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .periph_cs(periph_cs), .core_drv_en(core_drv_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one bus cycle: phase 1 drives bank, phase 2 drives other data; returns in phase 2
   task automatic bus_cycle(input logic [7:0] bank, input logic [15:0] lo,
                            input logic dv, input logic pv, input logic rw,
                            input logic [7:0] p2_data);
      @(negedge clk);
      phi2 = 1'b0; bus_in = bank; addr_lo = lo;
      data_valid = dv; prog_valid = pv; rd_wr_n = rw;
      @(negedge clk);
      phi2 = 1'b1; bus_in = p2_data;
      #1;
   endtask

   task automatic t_reset;
      // R9: phase-2-high before any phase-1 edge, write requested
      rd_wr_n = 1'b0; data_valid = 1'b1;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R9 bank zero", addr_full[23:16], 8'h00);
      chk("R9 no wr before arm", mem_wr, 1'b0);
      chk("R9 no drv before arm", core_drv_en, 1'b0);
      chk("R9 no cs before arm", periph_cs, 1'b0);
      bus_cycle(8'h12, 16'h3456, 1'b1, 1'b0, 1'b0, 8'hAA);
      chk("R9 wr after arm", mem_wr, 1'b1);
   endtask

   task automatic t_types;
      for (int k = 0; k < 4; k++) begin
         bus_cycle(8'h34, 16'h0100, k[1], k[0], 1'b1, 8'h55);
         chk("R1 cyc_type", cyc_type, k[1:0]);
         chk("R3 rd only when valid", mem_rd, (k != 0));
         chk("R6 drv on read", core_drv_en, 1'b1);
         chk("R4 no wr on read", mem_wr, 1'b0);
      end
      bus_cycle(8'h34, 16'h0100, 1'b0, 1'b0, 1'b0, 8'h55);
      chk("R4 wr on internal-flag write", mem_wr, 1'b1);
      chk("R6 no drv on write", core_drv_en, 1'b0);
      chk("R3 no rd on write", mem_rd, 1'b0);
   endtask

   task automatic t_latch;
      @(negedge clk);
      phi2 = 1'b0; bus_in = 8'h7E; addr_lo = 16'hBEEF;
      #1;
      chk("R2 transparent phase1", addr_full, 24'h7EBEEF);
      chk("R3 no rd in phase1", mem_rd, 1'b0);
      @(negedge clk); phi2 = 1'b1; bus_in = 8'hC3; #1;
      chk("R2 held phase2", addr_full, 24'h7EBEEF);
      bus_in = 8'h01; #1;
      chk("R2 ignores bus phase2", addr_full[23:16], 8'h7E);
   endtask

   task automatic t_emul;
      emul = 1'b1;
      bus_cycle(8'h9A, 16'h2222, 1'b1, 1'b0, 1'b1, 8'h9A);
      chk("R7 emul bank zero phase2", addr_full, 24'h002222);
      @(negedge clk); phi2 = 1'b0; bus_in = 8'h44; #1;
      chk("R7 emul bank zero phase1", addr_full[23:16], 8'h00);
      emul = 1'b0;
   endtask

   task automatic t_stall;
      bus_cycle(8'h12, 16'h0040, 1'b1, 1'b0, 1'b1, 8'hEE);
      chk("R5 read before stall", core_drv_en, 1'b1);
      @(negedge clk);
      rdy = 1'b0; rd_wr_n = 1'b0; bus_in = 8'h99; #1;
      chk("R5 drv held", core_drv_en, 1'b1);
      chk("R5 rd held", mem_rd, 1'b1);
      chk("R5 no wr in stall", mem_wr, 1'b0);
      phi2 = 1'b0; #1;
      chk("R5 bank held in stall", addr_full[23:16], 8'h12);
      @(negedge clk); phi2 = 1'b1; #1;
      chk("R5 bank held after stall edge", addr_full[23:16], 8'h12);
      chk("R5 drv held late", core_drv_en, 1'b1);
      @(negedge clk); rdy = 1'b1; rd_wr_n = 1'b1; #1;
   endtask

   task automatic t_window;
      bus_cycle(8'h12, 16'hFFFF, 1'b1, 1'b0, 1'b1, 8'h00);
      chk("R8 cs hit read", periph_cs, 1'b1);
      bus_cycle(8'h13, 16'h0000, 1'b1, 1'b0, 1'b0, 8'h00);
      chk("R8 cs miss masked bit", periph_cs, 1'b0);
      bus_cycle(8'h12, 16'h8000, 1'b0, 1'b0, 1'b1, 8'h00);
      chk("R8 cs blocked internal read", periph_cs, 1'b0);
      bus_cycle(8'h12, 16'h8000, 1'b0, 1'b0, 1'b0, 8'h00);
      chk("R8 cs on flagless write", periph_cs, 1'b1);
      win_mask = 24'hFF8000; win_base = 24'h128000;
      bus_cycle(8'h12, 16'h0001, 1'b0, 1'b1, 1'b1, 8'h00);
      chk("R8 cs miss low bit", periph_cs, 1'b0);
      bus_cycle(8'h12, 16'h8001, 1'b0, 1'b1, 1'b1, 8'h00);
      chk("R8 cs hit low bit", periph_cs, 1'b1);
   endtask

   initial begin : watchdog
      #1000000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_types();
      t_latch();
      t_emul();
      t_stall();
      t_window();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule